// File: doc/BRIEF.md
# Predicated Multi-Lane Vector Arithmetic Unit

This block carries out element-wise integer arithmetic on a private vector register file. A decoded instruction (operation, destination, two sources, a scalar operand and a mask selector) is presented together with a vector length. The unit then walks through the elements a group at a time: a fixed set of parallel lanes each handles one element per clock. Element i always belongs to lane i mod LANES and is processed in group i / LANES. All lanes get the same control and never exchange data.

Supported work is addition and multiplication in both vector-vector and scalar-vector forms, a not-equal compare that fills a one-bit-per-element mask register, and a subtract whose writes are gated by a chosen mask. Only elements below the vector length are touched. A one-cycle done pulse marks completion. A small test port loads and reads back vector elements and reads mask registers, so the unit can be exercised without any memory path.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset busy and done are low, every vector element reads 0 and every mask register reads 0.
- R2: An instruction is taken on a clock edge where start is high and busy is low; start while busy is high has no effect on any register or on the timing of the running operation.
- R3: After acceptance busy stays high for exactly ceil(VL/4) cycles (4 lanes, one group per cycle); done is high for exactly one cycle, the first cycle busy is low again, and all results are visible on the test port from then on.
- R4: With VL = 0 the unit is busy for one cycle, raises done, and writes no vector or mask register.
- R5: Elements whose index is at or above VL keep their old values in the destination vector and in the destination mask.
- R6: op 0 writes vd[i] = vs1[i] + vs2[i] and op 1 writes vd[i] = scalar + vs1[i], both modulo 2^32.
- R7: op 2 writes vd[i] = vs1[i] * vs2[i] and op 3 writes vd[i] = scalar * vs1[i], keeping the low 32 bits of the product.
- R8: op 4 writes bit i of mask register msel with 1 where vs1[i] differs from vs2[i] and 0 where they are equal; no vector register changes.
- R9: op 5 writes vd[i] = vs1[i] - vs2[i] (modulo 2^32) only where bit i of mask register msel is 1; elements with a 0 bit keep their prior value.
- R10: The test port writes element tp_elem of register tp_reg on a clock edge with tp_we high while busy is low, and tp_rdata and tp_mask show the selected element and mask register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid |
| op | input | 3 | Operation code (0..5, see requirements) |
| vd | input | 3 | Destination vector register |
| vs1 | input | 3 | First source vector register |
| vs2 | input | 3 | Second source vector register |
| msel | input | 2 | Mask register: destination for op 4, gate for op 5 |
| scalar | input | 32 | Scalar operand for ops 1 and 3 |
| vl | input | 6 | Vector length, 0 to 32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| tp_we | input | 1 | Test-port element write enable |
| tp_reg | input | 3 | Test-port vector register select |
| tp_elem | input | 5 | Test-port element index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data |
| tp_msel | input | 2 | Test-port mask register select |
| tp_mask | output | 32 | Selected mask register contents |

## Verification
The bench aims at vector lengths that end mid-group (13, 7, 5, 1) and at zero. A unit with a wrong group count would hold busy a cycle too long or too short, and one with a wrong element bound would overwrite the tail of the destination. Wrap-around sums and products whose upper bits must be dropped catch an arithmetic path of the wrong width. A second compare over a shorter length, on a mask that is already all ones, exposes a compare that clears bits past the length. A masked subtract exposes a mask that is ignored or read inverted. A start pulse injected mid-operation, aimed at an otherwise untouched register, shows whether a busy unit wrongly accepts a second instruction.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_VV = 3'd0,
        OP_ADD_SV = 3'd1,
        OP_MUL_VV = 3'd2,
        OP_MUL_SV = 3'd3,
        OP_CMP_NE = 3'd4,
        OP_SUB_MK = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } vop_e;

endpackage

// File: rtl/vlu_lane.sv
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int DW = 32
) (
    input  vop_e          op,
    input  logic          active,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] scal,
    input  logic [DW-1:0] old_val,
    input  logic          mask_bit,
    output logic          wr_en,
    output logic [DW-1:0] wr_val,
    output logic          differ
);

    logic [DW-1:0] rhs;

    always_comb begin
        rhs    = (op == OP_ADD_SV || op == OP_MUL_SV) ? scal : src_b;
        differ = (src_a != src_b);
        wr_en  = 1'b0;
        wr_val = old_val;
        unique case (op)
            OP_ADD_VV, OP_ADD_SV: begin
                wr_en  = active;
                wr_val = src_a + rhs;
            end
            OP_MUL_VV, OP_MUL_SV: begin
                wr_en  = active;
                wr_val = src_a * rhs;
            end
            OP_SUB_MK: begin
                wr_en  = active & mask_bit;
                wr_val = src_a - src_b;
            end
            default: begin
                wr_en  = 1'b0;
                wr_val = old_val;
            end
        endcase
    end

endmodule

// File: rtl/vlu_seq.sv
module vlu_seq #(
    parameter int ELEMS = 32,
    parameter int LANES = 4,
    localparam int VLW  = $clog2(ELEMS + 1),
    localparam int GW   = $clog2(ELEMS / LANES),
    localparam int LSH  = $clog2(LANES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    output logic           busy,
    output logic           done,
    output logic [GW-1:0]  grp,
    output logic [VLW-1:0] vl_len
);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [GW-1:0]  grp;
        logic [GW-1:0]  last;
        logic [VLW-1:0] len;
    } seq_t;

    seq_t           s_d, s_q;
    logic [VLW-1:0] len_clamp;
    logic [VLW-1:0] last_wide;

    always_comb begin
        len_clamp = (vl > VLW'(ELEMS)) ? VLW'(ELEMS) : vl;
        last_wide = (len_clamp == '0) ? '0 : ((len_clamp - VLW'(1)) >> LSH);
        s_d       = s_q;
        s_d.done  = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.grp  = '0;
                s_d.last = last_wide[GW-1:0];
                s_d.len  = len_clamp;
            end
        end else if (s_q.grp == s_q.last) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end else begin
            s_d.grp = s_q.grp + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign grp    = s_q.grp;
    assign vl_len = s_q.len;

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int ELEMS = 32,
    parameter int LANES = 4,
    parameter int NREG  = 8,
    parameter int NMASK = 4,
    localparam int RW   = $clog2(NREG),
    localparam int MW   = $clog2(NMASK),
    localparam int EW   = $clog2(ELEMS),
    localparam int VLW  = $clog2(ELEMS + 1),
    localparam int LW   = $clog2(LANES),
    localparam int GW   = $clog2(ELEMS / LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [RW-1:0]    vd,
    input  logic [RW-1:0]    vs1,
    input  logic [RW-1:0]    vs2,
    input  logic [MW-1:0]    msel,
    input  logic [DW-1:0]    scalar,
    input  logic [VLW-1:0]   vl,
    output logic             busy,
    output logic             done,
    input  logic             tp_we,
    input  logic [RW-1:0]    tp_reg,
    input  logic [EW-1:0]    tp_elem,
    input  logic [DW-1:0]    tp_wdata,
    output logic [DW-1:0]    tp_rdata,
    input  logic [MW-1:0]    tp_msel,
    output logic [ELEMS-1:0] tp_mask
);

    typedef struct packed {
        vop_e          op;
        logic [RW-1:0] vd;
        logic [RW-1:0] vs1;
        logic [RW-1:0] vs2;
        logic [MW-1:0] ms;
        logic [DW-1:0] scal;
    } instr_t;

    instr_t           ins_d, ins_q;
    logic [DW-1:0]    rf_d [NREG][ELEMS];
    logic [DW-1:0]    rf_q [NREG][ELEMS];
    logic [ELEMS-1:0] mk_d [NMASK];
    logic [ELEMS-1:0] mk_q [NMASK];

    logic [GW-1:0]    grp;
    logic [VLW-1:0]   vl_len;

    logic [EW-1:0]    ln_idx [LANES];
    logic             ln_act [LANES];
    logic             ln_wr  [LANES];
    logic [DW-1:0]    ln_res [LANES];
    logic             ln_ne  [LANES];

    vlu_seq #(.ELEMS(ELEMS), .LANES(LANES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .vl     (vl),
        .busy   (busy),
        .done   (done),
        .grp    (grp),
        .vl_len (vl_len)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ln_idx[g] = {grp, LW'(g)};
        assign ln_act[g] = busy && ({1'b0, ln_idx[g]} < vl_len);

        vlu_lane #(.DW(DW)) u_lane (
            .op       (ins_q.op),
            .active   (ln_act[g]),
            .src_a    (rf_q[ins_q.vs1][ln_idx[g]]),
            .src_b    (rf_q[ins_q.vs2][ln_idx[g]]),
            .scal     (ins_q.scal),
            .old_val  (rf_q[ins_q.vd][ln_idx[g]]),
            .mask_bit (mk_q[ins_q.ms][ln_idx[g]]),
            .wr_en    (ln_wr[g]),
            .wr_val   (ln_res[g]),
            .differ   (ln_ne[g])
        );
    end

    always_comb begin
        ins_d = ins_q;
        rf_d  = rf_q;
        mk_d  = mk_q;
        if (!busy) begin
            if (start) begin
                ins_d.op   = vop_e'(op);
                ins_d.vd   = vd;
                ins_d.vs1  = vs1;
                ins_d.vs2  = vs2;
                ins_d.ms   = msel;
                ins_d.scal = scalar;
            end
            if (tp_we) rf_d[tp_reg][tp_elem] = tp_wdata;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (ln_wr[l]) rf_d[ins_q.vd][ln_idx[l]] = ln_res[l];
                if (ins_q.op == OP_CMP_NE && ln_act[l])
                    mk_d[ins_q.ms][ln_idx[l]] = ln_ne[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q <= '0;
            for (int r = 0; r < NREG; r++)
                for (int e = 0; e < ELEMS; e++)
                    rf_q[r][e] <= '0;
            for (int m = 0; m < NMASK; m++)
                mk_q[m] <= '0;
        end else begin
            ins_q <= ins_d;
            rf_q  <= rf_d;
            mk_q  <= mk_d;
        end
    end

    assign tp_rdata = rf_q[tp_reg][tp_elem];
    assign tp_mask  = mk_q[tp_msel];

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
    parameter int VLW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [VLW-1:0] vl
);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl == '0) |=> (busy ##1 (done && !busy)));

endmodule

bind vec_lane_unit vlu_checker #(.VLW(VLW)) u_vlu_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .vl    (vl)
);

// File: tb/vec_lane_unit_test.sv
`timescale 1ns/1ps
module vec_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  vd = '0, vs1 = '0, vs2 = '0;
    logic [1:0]  msel = '0;
    logic [31:0] scalar = '0;
    logic [5:0]  vl = '0;
    logic        busy, done;
    logic        tp_we = 1'b0;
    logic [2:0]  tp_reg = '0;
    logic [4:0]  tp_elem = '0;
    logic [31:0] tp_wdata = '0;
    logic [31:0] tp_rdata;
    logic [1:0]  tp_msel = '0;
    logic [31:0] tp_mask;

    always #2.5 clk = ~clk;

    vec_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .vs1(vs1),
        .vs2(vs2), .msel(msel), .scalar(scalar), .vl(vl), .busy(busy),
        .done(done), .tp_we(tp_we), .tp_reg(tp_reg), .tp_elem(tp_elem),
        .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .tp_msel(tp_msel),
        .tp_mask(tp_mask)
    );

    typedef struct {
        bit          is_mask;
        int          r;
        int          e;
        logic [31:0] v;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_rf [8][32];
    logic [31:0] m_mk [4];
    int          n_tests = 0;
    int          n_fail = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tp_write(int r, int e, logic [31:0] v);
        @(negedge clk);
        tp_we = 1'b1; tp_reg = 3'(r); tp_elem = 5'(e); tp_wdata = v;
        @(negedge clk);
        tp_we = 1'b0;
        m_rf[r][e] = v;
    endtask

    // monitor: pop expected items and compare through the test port
    task automatic drain();
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            @(negedge clk);
            if (it.is_mask) begin
                tp_msel = 2'(it.r);
                #1 check(it.req, $sformatf("mask m%0d", it.r), tp_mask, it.v);
            end else begin
                tp_reg = 3'(it.r); tp_elem = 5'(it.e);
                #1 check(it.req, $sformatf("v%0d[%0d]", it.r, it.e), tp_rdata, it.v);
            end
        end
    endtask

    function automatic void push_vec(int r, int len, string req);
        for (int i = 0; i < 32; i++) begin
            exp_t it;
            it.is_mask = 0; it.r = r; it.e = i; it.v = m_rf[r][i];
            it.req = (i < len) ? req : "R5";
            sb.push_back(it);
        end
    endfunction

    // driver: updates the model, pushes expectations, runs the instruction
    task automatic exec(int o, int d, int a, int b, int m, logic [31:0] s, int len,
                        bit inject, string req);
        int cnt;
        int groups;
        logic [31:0] nxt [32];
        groups = (len == 0) ? 1 : (len + 3) / 4;
        for (int i = 0; i < 32; i++) nxt[i] = m_rf[d][i];
        for (int i = 0; i < len; i++) begin
            case (o)
                0: nxt[i] = m_rf[a][i] + m_rf[b][i];
                1: nxt[i] = s + m_rf[a][i];
                2: nxt[i] = m_rf[a][i] * m_rf[b][i];
                3: nxt[i] = s * m_rf[a][i];
                4: m_mk[m][i] = (m_rf[a][i] != m_rf[b][i]);
                5: if (m_mk[m][i]) nxt[i] = m_rf[a][i] - m_rf[b][i];
                default: ;
            endcase
        end
        for (int i = 0; i < 32; i++) m_rf[d][i] = nxt[i];
        if (o == 4) begin
            exp_t it;
            it.is_mask = 1; it.r = m; it.e = 0; it.v = m_mk[m]; it.req = req;
            sb.push_back(it);
            push_vec(d, 0, "R8");
        end else begin
            push_vec(d, len, req);
        end
        if (inject) push_vec(0, 0, "R2");

        @(negedge clk);
        op = 3'(o); vd = 3'(d); vs1 = 3'(a); vs2 = 3'(b); msel = 2'(m);
        scalar = s; vl = 6'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            if (inject && cnt == 1) begin
                op = 3'd0; vd = 3'd0; vs1 = 3'd1; vs2 = 3'd1; vl = 6'd32; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check((len == 0) ? "R4" : (inject ? "R2" : "R3"), "busy cycles", 32'(cnt), 32'(groups));
        check((len == 0) ? "R4" : "R3", "done at end", {31'b0, done}, 32'd1);
        @(negedge clk);
        check("R3", "done after pulse", {31'b0, done}, 32'd0);
        drain();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int e = 0; e < 32; e++) m_rf[r][e] = '0;
        for (int m = 0; m < 4; m++) m_mk[m] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", {31'b0, busy}, 32'd0);
        check("R1", "done after reset", {31'b0, done}, 32'd0);
        tp_reg = 3'd6; tp_elem = 5'd17; tp_msel = 2'd3;
        #1 check("R1", "v6[17] after reset", tp_rdata, 32'd0);
        check("R1", "m3 after reset", tp_mask, 32'd0);

        for (int i = 0; i < 32; i++) begin
            tp_write(0, i, 32'hA000_0000 + 32'(i));
            tp_write(1, i, 32'(i * 3 + 1));
            tp_write(2, i, (i % 3 == 0) ? 32'(i * 3 + 1) : 32'(i + 100));
            tp_write(3, i, 32'hFFFF_FFF0 + 32'(i));
            tp_write(5, i, 32'h5555_0000 + 32'(i));
            tp_write(6, i, 32'h6666_0000 + 32'(i));
            tp_write(7, i, 32'h7777_0000 + 32'(i));
        end
        push_vec(3, 32, "R10");
        push_vec(2, 32, "R10");
        drain();

        exec(0, 4, 1, 3, 0, 32'h0, 32, 1'b1, "R6");           // wrap add, start while busy
        exec(1, 5, 1, 0, 0, 32'hFFFF_FFFF, 13, 1'b0, "R6");   // scalar add, partial group
        exec(2, 6, 3, 1, 0, 32'h0, 7, 1'b0, "R7");            // vector multiply
        exec(3, 6, 3, 0, 0, 32'h0001_0001, 4, 1'b0, "R7");    // scalar multiply, one group
        exec(4, 4, 1, 3, 1, 32'h0, 32, 1'b0, "R8");           // all differ -> all ones
        exec(4, 4, 1, 2, 1, 32'h0, 20, 1'b0, "R8");           // shorter compare, tail kept
        exec(5, 7, 1, 2, 1, 32'h0, 32, 1'b0, "R9");           // masked subtract
        exec(0, 4, 1, 3, 0, 32'h0, 0, 1'b0, "R4");            // zero length
        exec(1, 5, 1, 0, 0, 32'd5, 1, 1'b0, "R6");            // single element
        exec(4, 0, 1, 2, 2, 32'h0, 5, 1'b0, "R8");            // compare into clear mask

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule